// File: doc/BRIEF.md
# Two-Requester SRAM Access Arbiter

This block sits in front of one single-port synchronous SRAM and shares it between two requesters: a processor port and a backdoor port, such as a DMA engine or a debug path. Each cycle it grants at most one request, drives the SRAM strobes for the winner and returns a completion one cycle later. Read data, write completion and any error response all arrive in that cycle.

A two-bit policy input selects how contention is resolved. The four policies are:

- plain alternation;
- alternation biased toward the backdoor, in which the backdoor may win twice in a row and then yields once;
- strict processor priority;
- strict backdoor priority.

A separate protect input turns every write into an error response. A protected write still occupies its slot but never reaches the array.

The grant is a combinational function of the current requests and the registered arbitration state, so a requester that sees its grant may present a new request in the next cycle. A requester that is not granted keeps its request, and the same address and data, asserted until it is granted.

Top module: `sram_port_arbiter`

## Requirements
- R1: At most one of `cpu_gnt` and `bd_gnt` is high in any cycle. A grant is only given to a port whose request is high. A port that requests alone is granted in that same cycle.
- R2: With `cfg_mode` = 2'b00, a cycle where both ports request grants the port that was not granted most recently.
- R3: With `cfg_mode` = 2'b01, contention goes to the backdoor, except when the two most recent grants were both backdoor grants. In that case the processor wins, so a sustained contention yields backdoor, backdoor, processor, repeating.
- R4: With `cfg_mode` = 2'b10, a requesting processor always wins over the backdoor.
- R5: With `cfg_mode` = 2'b11, a requesting backdoor always wins over the processor.
- R6: In the grant cycle, a granted access drives `ram_en`, `ram_addr`, `ram_wdata` and `ram_we` (high for writes) from the winning port. The winning port's `*_done` is high exactly one cycle later, and in that cycle `*_rdata` carries the data read.
- R7: While `cfg_wprot` is 1, a granted write keeps `ram_en` and `ram_we` low, so memory is unchanged. That port's `*_done` and `*_err` are both high one cycle after the grant. Reads are unaffected.
- R8: The policy in force at each decision is the value of `cfg_mode` in that cycle. A change applies from the very next contention and does not disturb a completion already pending.
- R9: While `rst` is high, no grant, SRAM strobe, completion or error is asserted, even with requests present. After reset, the first plain-alternation contention goes to the processor, and the backdoor-biased mode starts with no backdoor run counted.
- R10: Reads and unprotected writes complete with `*_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Arbitration policy: 00 alternate, 01 backdoor-biased alternate, 10 processor first, 11 backdoor first |
| cfg_wprot | input | 1 | Write protect: writes end in an error response |
| cpu_req | input | 1 | Processor request, held until granted |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_gnt | output | 1 | Processor request accepted this cycle |
| cpu_done | output | 1 | Processor access completes (one cycle after grant) |
| cpu_err | output | 1 | Processor access ended in an error |
| cpu_rdata | output | DATA_W | Processor read data, valid with cpu_done |
| bd_req | input | 1 | Backdoor request, held until granted |
| bd_we | input | 1 | Backdoor write (1) or read (0) |
| bd_addr | input | ADDR_W | Backdoor word address |
| bd_wdata | input | DATA_W | Backdoor write data |
| bd_gnt | output | 1 | Backdoor request accepted this cycle |
| bd_done | output | 1 | Backdoor access completes |
| bd_err | output | 1 | Backdoor access ended in an error |
| bd_rdata | output | DATA_W | Backdoor read data, valid with bd_done |
| ram_en | output | 1 | SRAM access strobe |
| ram_we | output | 1 | SRAM write strobe |
| ram_addr | output | ADDR_W | SRAM address |
| ram_wdata | output | DATA_W | SRAM write data |
| ram_rdata | input | DATA_W | SRAM read data, one cycle after ram_en |

## Verification
The bench builds the block with a 6-bit address and 16-bit data. This keeps its behavioural SRAM model at 64 words, so each written word can be read back through the ports. The backdoor run limit stays at its default of two. That keeps the full biased pattern within a six-cycle contention sequence, and lets the run-limit property in the picker be checked.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

  typedef enum logic [1:0] {
    POL_ALT     = 2'b00,
    POL_ALT_BD  = 2'b01,
    POL_CPU_HI  = 2'b10,
    POL_BD_HI   = 2'b11
  } arb_pol_e;

  localparam int PORT_CPU = 0;
  localparam int PORT_BD  = 1;
  localparam int N_PORTS  = 2;

endpackage

// File: rtl/sram_arb_pick.sv
module sram_arb_pick
  import sram_arb_pkg::*;
#(
  parameter int BD_RUN = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  arb_pol_e            pol,
  input  logic [N_PORTS-1:0]  req,
  output logic [N_PORTS-1:0]  gnt
);

  localparam int RUN_W = $clog2(BD_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(BD_RUN);

  logic             last_bd;
  logic [RUN_W-1:0] bd_run;
  logic             both;
  logic             take_bd;

  always_comb begin
    both    = req[PORT_CPU] & req[PORT_BD];
    take_bd = 1'b0;
    if (both) begin
      case (pol)
        POL_ALT:    take_bd = ~last_bd;
        POL_ALT_BD: take_bd = (bd_run < RUN_MAX);
        POL_CPU_HI: take_bd = 1'b0;
        default:    take_bd = 1'b1;
      endcase
    end else begin
      take_bd = req[PORT_BD];
    end
    gnt           = '0;
    gnt[PORT_BD]  = ~rst & req[PORT_BD] & take_bd;
    gnt[PORT_CPU] = ~rst & req[PORT_CPU] & ~take_bd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_bd <= 1'b1;
      bd_run  <= '0;
    end else if (gnt[PORT_BD]) begin
      last_bd <= 1'b1;
      if (bd_run < RUN_MAX) bd_run <= bd_run + 1'b1;
    end else if (gnt[PORT_CPU]) begin
      last_bd <= 1'b0;
      bd_run  <= '0;
    end
  end

  // R1: a single winner, only among requesters, lone requester served
  a_r1_one_grant: assert property (@(posedge clk) disable iff (rst)
    !(gnt[PORT_CPU] && gnt[PORT_BD]));
  a_r1_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    ((gnt & ~req) == '0));
  a_r1_lone_served: assert property (@(posedge clk) disable iff (rst)
    (req[PORT_CPU] ^ req[PORT_BD]) |-> (gnt != '0));

  // R2: consecutive alternation contentions never repeat the processor
  a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
    (both && pol == POL_ALT && gnt[PORT_CPU])
      |=> !(both && pol == POL_ALT && gnt[PORT_CPU]));

  // R4, R5: fixed priorities
  a_r4_cpu_first: assert property (@(posedge clk) disable iff (rst)
    (pol == POL_CPU_HI && req[PORT_CPU]) |-> gnt[PORT_CPU]);
  a_r5_bd_first: assert property (@(posedge clk) disable iff (rst)
    (pol == POL_BD_HI && req[PORT_BD]) |-> gnt[PORT_BD]);

  generate
    if (BD_RUN == 2) begin : g_run_chk
      // R3: after two contention wins by the backdoor, the processor wins
      a_r3_bd_yields: assert property (@(posedge clk) disable iff (rst)
        (both && pol == POL_ALT_BD && gnt[PORT_BD] &&
         $past(!rst && both && pol == POL_ALT_BD && gnt[PORT_BD]))
          |=> (!(both && pol == POL_ALT_BD) || gnt[PORT_CPU]));
    end
  endgenerate

endmodule

// File: rtl/sram_arb_mux.sv
module sram_arb_mux
  import sram_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wprot,
  input  logic [N_PORTS-1:0]  gnt,
  input  logic [N_PORTS-1:0]  we,
  input  logic [ADDR_W-1:0]   addr [N_PORTS],
  input  logic [DATA_W-1:0]   wdata [N_PORTS],
  output logic                ram_en,
  output logic                ram_we,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [DATA_W-1:0]   ram_wdata
);

  logic sel_bd;
  logic sel_we;
  logic any;
  logic blocked;

  always_comb begin
    sel_bd    = gnt[PORT_BD];
    any       = |gnt;
    sel_we    = sel_bd ? we[PORT_BD] : we[PORT_CPU];
    blocked   = sel_we & wprot;
    ram_en    = any & ~blocked;
    ram_we    = any & sel_we & ~wprot;
    ram_addr  = sel_bd ? addr[PORT_BD]  : addr[PORT_CPU];
    ram_wdata = sel_bd ? wdata[PORT_BD] : wdata[PORT_CPU];
  end

  // R7: a protected write never strobes the array
  a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (wprot && ((gnt & we) != '0)) |-> (!ram_en && !ram_we));

  // R6: a granted unprotected access always strobes the array
  a_r6_strobe: assert property (@(posedge clk) disable iff (rst)
    ((gnt != '0) && ((gnt & we) == '0 || !wprot)) |-> ram_en);

endmodule

// File: rtl/sram_arb_resp.sv
module sram_arb_resp
  import sram_arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wprot,
  input  logic [N_PORTS-1:0]  gnt,
  input  logic [N_PORTS-1:0]  we,
  output logic [N_PORTS-1:0]  done,
  output logic [N_PORTS-1:0]  err
);

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) begin
          done[p] <= 1'b0;
          err[p]  <= 1'b0;
        end else begin
          done[p] <= gnt[p];
          err[p]  <= gnt[p] & we[p] & wprot;
        end
      end

      // R6: completion one cycle after each grant, none without
      a_r6_done_follows: assert property (@(posedge clk) disable iff (rst)
        gnt[p] |=> done[p]);
      a_r6_no_stray_done: assert property (@(posedge clk) disable iff (rst)
        !gnt[p] |=> !done[p]);
      // R7, R10: error only on a protected write
      a_r7_err_on_prot: assert property (@(posedge clk) disable iff (rst)
        (gnt[p] && we[p] && wprot) |=> err[p]);
      a_r10_no_err: assert property (@(posedge clk) disable iff (rst)
        (gnt[p] && !(we[p] && wprot)) |=> !err[p]);
    end
  endgenerate

endmodule

// File: rtl/sram_port_arbiter.sv
module sram_port_arbiter
  import sram_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BD_RUN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_wprot,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_gnt,
  output logic              cpu_done,
  output logic              cpu_err,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bd_req,
  input  logic              bd_we,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic [DATA_W-1:0] bd_wdata,
  output logic              bd_gnt,
  output logic              bd_done,
  output logic              bd_err,
  output logic [DATA_W-1:0] bd_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  logic [N_PORTS-1:0] req;
  logic [N_PORTS-1:0] we;
  logic [N_PORTS-1:0] gnt;
  logic [N_PORTS-1:0] done;
  logic [N_PORTS-1:0] err;
  logic [ADDR_W-1:0]  addr  [N_PORTS];
  logic [DATA_W-1:0]  wdata [N_PORTS];

  always_comb begin
    req[PORT_CPU]   = cpu_req;
    req[PORT_BD]    = bd_req;
    we[PORT_CPU]    = cpu_we;
    we[PORT_BD]     = bd_we;
    addr[PORT_CPU]  = cpu_addr;
    addr[PORT_BD]   = bd_addr;
    wdata[PORT_CPU] = cpu_wdata;
    wdata[PORT_BD]  = bd_wdata;
  end

  sram_arb_pick #(.BD_RUN(BD_RUN)) pick_i (
    .clk (clk),
    .rst (rst),
    .pol (arb_pol_e'(cfg_mode)),
    .req (req),
    .gnt (gnt)
  );

  sram_arb_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mux_i (
    .clk       (clk),
    .rst       (rst),
    .wprot     (cfg_wprot),
    .gnt       (gnt),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  sram_arb_resp resp_i (
    .clk   (clk),
    .rst   (rst),
    .wprot (cfg_wprot),
    .gnt   (gnt),
    .we    (we),
    .done  (done),
    .err   (err)
  );

  assign cpu_gnt   = gnt[PORT_CPU];
  assign bd_gnt    = gnt[PORT_BD];
  assign cpu_done  = done[PORT_CPU];
  assign bd_done   = done[PORT_BD];
  assign cpu_err   = err[PORT_CPU];
  assign bd_err    = err[PORT_BD];
  assign cpu_rdata = ram_rdata;
  assign bd_rdata  = ram_rdata;

  // R9: nothing is granted or strobed while reset is held
  a_r9_quiet_reset: assert property (@(posedge clk)
    rst |-> (!cpu_gnt && !bd_gnt && !ram_en));

endmodule

// File: tb/sram_port_arbiter_tb.sv
module sram_port_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_wprot = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic bd_req = 1'b0, bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [DW-1:0] bd_wdata = '0;
  logic cpu_gnt, cpu_done, cpu_err, bd_gnt, bd_done, bd_err;
  logic [DW-1:0] cpu_rdata, bd_rdata;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;
  logic [DW-1:0] mem [2**AW];

  int n_chk = 0;
  int n_fail = 0;

  logic s_cg, s_bg, s_en, s_we, s_cd, s_ce, s_bdn, s_be;
  logic [DW-1:0] s_crd, s_brd;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = DW'(i * 3);
  end

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  sram_port_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_wprot(cfg_wprot),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_gnt(cpu_gnt), .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .bd_req(bd_req), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
    .bd_gnt(bd_gnt), .bd_done(bd_done), .bd_err(bd_err), .bd_rdata(bd_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, capture grant, wait one cycle, capture response
  task automatic step(input logic cr, input logic cw, input logic [AW-1:0] ca,
                      input logic [DW-1:0] cd, input logic br, input logic bw,
                      input logic [AW-1:0] ba, input logic [DW-1:0] bdt);
    cpu_req = cr; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    bd_req = br;  bd_we = bw;  bd_addr = ba;  bd_wdata = bdt;
    #1;
    s_cg = cpu_gnt; s_bg = bd_gnt; s_en = ram_en; s_we = ram_we;
    @(negedge clk);
    s_cd = cpu_done; s_ce = cpu_err; s_crd = cpu_rdata;
    s_bdn = bd_done; s_be = bd_err; s_brd = bd_rdata;
  endtask

  task automatic idle();
    step(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_mode = 2'b00; cfg_wprot = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; cpu_req = 1'b1; bd_req = 1'b1;
    #1;
    chk(!cpu_gnt && !bd_gnt && !ram_en, "R9 no grant in reset",
        {cpu_gnt, bd_gnt, ram_en}, 0);
    @(negedge clk);
    chk(!cpu_done && !bd_done && !cpu_err && !bd_err, "R9 no response in reset",
        {cpu_done, bd_done, cpu_err, bd_err}, 0);
    cpu_req = 1'b0; bd_req = 1'b0;
    rst = 1'b0;
  endtask

  task automatic t_datapath();
    do_reset();
    step(1, 1, 6'd3, 16'h1234, 0, 0, '0, '0);
    chk(s_cg && !s_bg && s_en && s_we, "R1 lone cpu write granted", {s_cg, s_bg, s_en, s_we}, 4'b1011);
    chk(s_cd && !s_ce, "R10 write done no err", {s_cd, s_ce}, 2'b10);
    step(0, 0, '0, '0, 1, 0, 6'd3, '0);
    chk(s_bg && !s_cg && s_en && !s_we, "R1 lone bd read granted", {s_cg, s_bg, s_en, s_we}, 4'b0110);
    chk(s_bdn && !s_be && s_brd == 16'h1234, "R6 bd read data", s_brd, 16'h1234);
    step(1, 0, 6'd10, '0, 0, 0, '0, '0);
    chk(s_cd && s_crd == 16'd30, "R6 cpu read data", s_crd, 16'd30);
    idle();
    chk(!s_cg && !s_bg && !s_cd && !s_bdn, "R1 idle no grant", {s_cg, s_bg, s_cd, s_bdn}, 0);
  endtask

  task automatic run_contention(input logic [1:0] mode, input string tag,
                                input logic [5:0] exp_bd, input int n);
    do_reset();
    cfg_mode = mode;
    for (int i = 0; i < n; i++) begin
      step(1, 0, 6'd1, '0, 1, 0, 6'd2, '0);
      chk(s_bg == exp_bd[i] && s_cg == !exp_bd[i], tag, {s_cg, s_bg}, {!exp_bd[i], exp_bd[i]});
      chk(exp_bd[i] ? (s_bdn && !s_cd) : (s_cd && !s_bdn), "R6 winner completes",
          {s_cd, s_bdn}, {!exp_bd[i], exp_bd[i]});
    end
    idle();
  endtask

  task automatic t_modes();
    run_contention(2'b00, "R2 alternation order", 6'b101010, 6);
    run_contention(2'b01, "R3 biased order", 6'b011011, 6);
    run_contention(2'b10, "R4 cpu first", 6'b000000, 3);
    run_contention(2'b11, "R5 bd first", 6'b111111, 3);
  endtask

  task automatic t_switch();
    do_reset();
    cfg_mode = 2'b11;
    step(1, 0, 6'd4, '0, 1, 0, 6'd5, '0);
    chk(s_bg && !s_cg, "R8 mode 11 picks bd", {s_cg, s_bg}, 2'b01);
    cfg_mode = 2'b10;
    step(1, 0, 6'd4, '0, 1, 0, 6'd5, '0);
    chk(s_cg && !s_bg, "R8 switch to 10 picks cpu", {s_cg, s_bg}, 2'b10);
    chk(s_cd && s_crd == 16'd12, "R8 cpu read after switch", s_crd, 16'd12);
    step(0, 0, '0, '0, 1, 0, 6'd5, '0);
    chk(s_bg && s_brd == 16'd15, "R1 held bd request served", s_brd, 16'd15);
    idle();
  endtask

  task automatic t_wprot();
    do_reset();
    step(1, 1, 6'd9, 16'hBEEF, 0, 0, '0, '0);
    chk(s_cd && !s_ce, "R10 unprotected write ok", {s_cd, s_ce}, 2'b10);
    cfg_wprot = 1'b1;
    step(1, 1, 6'd9, 16'h1111, 0, 0, '0, '0);
    chk(s_cg && !s_en && !s_we, "R7 protected write no strobe", {s_cg, s_en, s_we}, 3'b100);
    chk(s_cd && s_ce, "R7 protected write error", {s_cd, s_ce}, 2'b11);
    step(0, 0, '0, '0, 1, 0, 6'd9, '0);
    chk(s_bdn && !s_be && s_brd == 16'hBEEF, "R7 read under protect, mem intact", s_brd, 16'hBEEF);
    step(0, 0, '0, '0, 1, 1, 6'd9, 16'h2222);
    chk(s_bdn && s_be, "R7 bd protected write error", {s_bdn, s_be}, 2'b11);
    cfg_wprot = 1'b0;
    step(1, 0, 6'd9, '0, 0, 0, '0, '0);
    chk(s_cd && !s_ce && s_crd == 16'hBEEF, "R7 memory unchanged", s_crd, 16'hBEEF);
    idle();
  endtask

  initial begin
    t_reset();
    t_datapath();
    t_modes();
    t_switch();
    t_wprot();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule